// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This unit sits beside the execute stage of a five-stage in-order pipeline. For each of the two ALU source operands of the instruction now in execute, it picks where the value comes from. The value can come from the register file read made during decode. It can also come from the result held one stage ahead, at the output of execute. Or it can come from the value held two stages ahead, at the end of the memory stage, which is either loaded data or an older ALU result.

The unit is purely combinational. It compares the two source register numbers of the execute-stage instruction against the destination number and write flag of the two younger-result stages. It returns one 2-bit select per operand, and those selects steer the operand multiplexers in the same cycle. When both later stages target the same register, the nearer stage wins, because it holds the most recent write. Register 0 is hard-wired to zero, so a write to it is never forwarded.

Top module: `fwd_select_unit`

## Requirements
- R1: With no qualifying match for an operand, its select is 2'b00 (take the register file value).
- R2: If the execute/memory stage writes (`ex_wr_en`=1) a nonzero destination equal to an operand's source number, that operand's select is 2'b10.
- R3: If the memory/writeback stage writes (`mem_wr_en`=1) a nonzero destination equal to the source number, and R2 does not apply to that operand, the select is 2'b01.
- R4: When both stages qualify for the same operand, the select is 2'b10 (the nearer result wins).
- R5: A source or destination number of 0 never produces forwarding: a source number of 0 always yields 2'b00.
- R6: A stage with its write flag low has no effect on either select, whatever its destination number.
- R7: Operand A (`src1_idx` to `sel_a`) and operand B (`src2_idx` to `sel_b`) are decided independently by the same rules.
- R8: The code 2'b11 is never produced on either select.
- R9: In a chain of three back-to-back instructions that each read and write the same nonzero register, every consumer gets select 2'b10. This holds for the third one too, while both later stages match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src1_idx | input | 5 | First source register number of the execute-stage instruction |
| src2_idx | input | 5 | Second source register number of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute/memory stage will write a register |
| ex_wr_idx | input | 5 | Execute/memory stage destination register number |
| mem_wr_en | input | 1 | Memory/writeback stage will write a register |
| mem_wr_idx | input | 5 | Memory/writeback stage destination register number |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding |

## Verification
The bench targets the double-hazard case where both later stages hold the same destination. A unit without the priority rule would return the stale 2'b01 or the illegal 2'b11 there. It drives destination 0 with its write flag set, where a unit missing the zero check would forward a value that must read as zero. It also drives matching destinations with write flags low, where a unit ignoring the flags would forward from a store or a branch. Random vectors draw register numbers from a small range, so single matches, double matches and cross-operand matches come up often. They show whether one operand's decision leaks into the other's.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } src_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
  parameter int unsigned AW = 5
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [AW-1:0] src_idx,
  output logic          hit
);

  logic dst_nonzero;

  // register 0 reads as constant zero, so it is never a forwarding source
  assign dst_nonzero = |wr_idx;
  assign hit         = wr_en && dst_nonzero && (wr_idx == src_idx);

endmodule

// File: rtl/fwd_prio_pick.sv
module fwd_prio_pick
  import fwd_pkg::*;
(
  input  logic     near_hit,
  input  logic     far_hit,
  output src_sel_e sel
);

  always_comb begin
    if (near_hit)     sel = SRC_EXMEM;
    else if (far_hit) sel = SRC_MEMWB;
    else              sel = SRC_REGFILE;
  end

endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          [AW-1:0]    src1_idx,
  input  logic          [AW-1:0]    src2_idx,
  input  logic                      ex_wr_en,
  input  logic          [AW-1:0]    ex_wr_idx,
  input  logic                      mem_wr_en,
  input  logic          [AW-1:0]    mem_wr_idx,
  output logic          [SEL_W-1:0] sel_a,
  output logic          [SEL_W-1:0] sel_b
);

  localparam int unsigned NSRC = 2;

  logic     [NSRC-1:0][AW-1:0] src_vec;
  logic     [NSRC-1:0]         near_hit;
  logic     [NSRC-1:0]         far_hit;
  src_sel_e                    sel_vec [NSRC];

  assign src_vec[0] = src1_idx;
  assign src_vec[1] = src2_idx;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    fwd_stage_match #(.AW(AW)) u_near (
      .wr_en   (ex_wr_en),
      .wr_idx  (ex_wr_idx),
      .src_idx (src_vec[g]),
      .hit     (near_hit[g])
    );

    fwd_stage_match #(.AW(AW)) u_far (
      .wr_en   (mem_wr_en),
      .wr_idx  (mem_wr_idx),
      .src_idx (src_vec[g]),
      .hit     (far_hit[g])
    );

    fwd_prio_pick u_pick (
      .near_hit (near_hit[g]),
      .far_hit  (far_hit[g]),
      .sel      (sel_vec[g])
    );
  end

  assign sel_a = sel_vec[0];
  assign sel_b = sel_vec[1];

endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] src1_idx,
  input logic [AW-1:0] src2_idx,
  input logic          ex_wr_en,
  input logic [AW-1:0] ex_wr_idx,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_wr_idx,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b
);

  always_comb begin
    // R8
    a_r8_no_reserved_code: assert (sel_a != 2'b11 && sel_b != 2'b11);

    // R2: an execute/memory select needs a qualifying write there
    if (sel_a == 2'b10)
      a_r2_near_justified_a: assert (ex_wr_en && ex_wr_idx != '0 && ex_wr_idx == src1_idx);
    if (sel_b == 2'b10)
      a_r2_near_justified_b: assert (ex_wr_en && ex_wr_idx != '0 && ex_wr_idx == src2_idx);

    // R3: a memory/writeback select needs a qualifying write there
    if (sel_a == 2'b01)
      a_r3_far_justified_a: assert (mem_wr_en && mem_wr_idx != '0 && mem_wr_idx == src1_idx);
    if (sel_b == 2'b01)
      a_r3_far_justified_b: assert (mem_wr_en && mem_wr_idx != '0 && mem_wr_idx == src2_idx);

    // R4: the nearer stage wins whenever it qualifies
    if (ex_wr_en && ex_wr_idx != '0 && ex_wr_idx == src1_idx)
      a_r4_near_wins_a: assert (sel_a == 2'b10);
    if (ex_wr_en && ex_wr_idx != '0 && ex_wr_idx == src2_idx)
      a_r4_near_wins_b: assert (sel_b == 2'b10);

    // R5: register 0 never forwarded
    if (src1_idx == '0)
      a_r5_zero_src_a: assert (sel_a == 2'b00);
    if (src2_idx == '0)
      a_r5_zero_src_b: assert (sel_b == 2'b00);

    // R6: both write flags low leaves the register file as source
    if (!ex_wr_en && !mem_wr_en)
      a_r6_no_writers: assert (sel_a == 2'b00 && sel_b == 2'b00);
  end

endmodule

bind fwd_select_unit fwd_select_chk #(.AW(AW)) u_chk (
  .src1_idx   (src1_idx),
  .src2_idx   (src2_idx),
  .ex_wr_en   (ex_wr_en),
  .ex_wr_idx  (ex_wr_idx),
  .mem_wr_en  (mem_wr_en),
  .mem_wr_idx (mem_wr_idx),
  .sel_a      (sel_a),
  .sel_b      (sel_b)
);

// File: tb/sim_fwd_select_unit.sv
module sim_fwd_select_unit;

  localparam int unsigned AW      = 5;
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic [AW-1:0] src1_idx, src2_idx, ex_wr_idx, mem_wr_idx;
  logic          ex_wr_en, mem_wr_en;
  logic [1:0]    sel_a, sel_b;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  fwd_select_unit #(.AW(AW)) u0 (
    .src1_idx   (src1_idx),
    .src2_idx   (src2_idx),
    .ex_wr_en   (ex_wr_en),
    .ex_wr_idx  (ex_wr_idx),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_idx (mem_wr_idx),
    .sel_a      (sel_a),
    .sel_b      (sel_b)
  );

  // model of R1..R5: near stage first, then far stage, register 0 excluded
  function automatic logic [1:0] model(input logic [AW-1:0] src,
                                       input logic ee, input logic [AW-1:0] ei,
                                       input logic me, input logic [AW-1:0] mi);
    if (ee && ei != 0 && ei == src)      return 2'b10;
    else if (me && mi != 0 && mi == src) return 2'b01;
    else                                 return 2'b00;
  endfunction

  task automatic apply(input logic [AW-1:0] s1, input logic [AW-1:0] s2,
                       input logic ee, input logic [AW-1:0] ei,
                       input logic me, input logic [AW-1:0] mi);
    @(negedge clk);
    src1_idx = s1; src2_idx = s2;
    ex_wr_en = ee; ex_wr_idx = ei;
    mem_wr_en = me; mem_wr_idx = mi;
    #1;
  endtask

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_both(input string tag);
    chk({tag, " A"}, sel_a, model(src1_idx, ex_wr_en, ex_wr_idx, mem_wr_en, mem_wr_idx));
    chk({tag, " B"}, sel_b, model(src2_idx, ex_wr_en, ex_wr_idx, mem_wr_en, mem_wr_idx));
  endtask

  initial begin
    src1_idx = '0; src2_idx = '0; ex_wr_en = 1'b0; ex_wr_idx = '0;
    mem_wr_en = 1'b0; mem_wr_idx = '0;

    // R1: idle state, no writers
    apply(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
    chk("R1 idle A", sel_a, 2'b00);
    chk("R1 idle B", sel_b, 2'b00);
    apply(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
    chk("R1 no match A", sel_a, 2'b00);
    chk("R1 no match B", sel_b, 2'b00);

    // R2
    apply(5'd9, 5'd4, 1'b1, 5'd9, 1'b0, 5'd0);
    chk("R2 near A", sel_a, 2'b10);
    chk("R2 other B", sel_b, 2'b00);

    // R3
    apply(5'd4, 5'd12, 1'b1, 5'd5, 1'b1, 5'd12);
    chk("R3 far B", sel_b, 2'b01);
    chk("R3 other A", sel_a, 2'b00);

    // R4: both stages match the same source
    apply(5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 5'd6);
    chk("R4 double A", sel_a, 2'b10);
    chk("R4 double B", sel_b, 2'b10);

    // R5: writes to register 0 never forwarded
    apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    chk("R5 zero A", sel_a, 2'b00);
    chk("R5 zero B", sel_b, 2'b00);
    apply(5'd0, 5'd2, 1'b1, 5'd0, 1'b1, 5'd2);
    chk("R5 zero near, far hit B", sel_b, 2'b01);

    // R6: write flags low suppress matching destinations
    apply(5'd11, 5'd11, 1'b0, 5'd11, 1'b0, 5'd11);
    chk("R6 flags low A", sel_a, 2'b00);
    chk("R6 flags low B", sel_b, 2'b00);
    apply(5'd11, 5'd13, 1'b0, 5'd11, 1'b1, 5'd11);
    chk("R6 near off far on A", sel_a, 2'b01);

    // R7: operands take different sources at once
    apply(5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
    chk("R7 split A", sel_a, 2'b10);
    chk("R7 split B", sel_b, 2'b01);

    // R9: chain of three dependent writers/readers of register 1
    apply(5'd1, 5'd2, 1'b1, 5'd1, 1'b0, 5'd0);
    chk("R9 second consumer A", sel_a, 2'b10);
    apply(5'd1, 5'd3, 1'b1, 5'd1, 1'b1, 5'd1);
    chk("R9 third consumer A", sel_a, 2'b10);
    chk("R9 third consumer B", sel_b, 2'b00);

    // random mix, small index range for frequent matches; R8 checked on every vector
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)));
      chk_both("R7 random");
      chk("R8 no code 11", {sel_a == 2'b11 || sel_b == 2'b11, 1'b0}, 2'b00);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule